// File: doc/BRIEF.md
# Interrupt Controller Command Interface

This block is the processor-facing register front end of an eight-level interrupt controller. It samples a chip select, a write strobe, a read strobe, one address bit and an 8-bit write data bus on the system clock. A write takes effect once, on the clock where the write strobe is first seen high again after being seen low with the chip selected. The block runs a start-up sequence of two to four setup words, then sorts later writes into a mask load, a priority/end-of-interrupt command, or a read/mode command. The priority core beside it receives steady configuration outputs and one-cycle command pulses.

Reads return the request register or the in-service register, chosen by a persistent setting, or the mask register when the address bit is 1. A poll command turns the next read at address 0 into a software acknowledge: it returns a pending flag and the winning level, and emits a one-cycle acknowledge pulse to the core when a request was pending. Priority resolution and the vector returned during a hardware acknowledge belong to the core, not to this block.

Top module: `picCmdIf`

## Requirements
- R1: A write commits exactly once, on the first clock edge that samples `wrN` high after an edge that sampled `wrN` low and `csN` low; the address and data used are the ones sampled at that earlier edge. A write strobe pulsed while `csN` is high changes nothing.
- R2: A write with `addr`=0 and data bit 4 = 1 is setup word 1 in any state, and restarts the sequence: `initReady` drops, `maskBits` becomes 0, `specMask` 0, the register-read choice returns to the request register, `cascadeCfg` becomes 8'h07, any armed poll is cancelled, and `initPulse` is high for one cycle.
- R3: Setup word 1 fields: bit 3 drives `levelTrig`, bit 2 drives `intervalFour`, bit 1 drives `singleMode`, bit 0 states that word 4 will follow.
- R4: After word 1 the next write is word 2 and loads `vecBase`; word 3 (loads `cascadeCfg`) follows only when the single bit was 0; word 4 follows only when bit 0 of word 1 was 1; after the last expected word `initReady` goes high.
- R5: Setup word 4 fields: bit 4 `nestSpecial`, bit 3 `bufMode`, bit 2 `masterSel`, bit 1 `autoEoi`, bit 0 `cpuMode`. All five are 0 after word 1 until a word 4 is written, and stay 0 when no word 4 is requested.
- R6: Once `initReady` is high, a write with `addr`=1 loads `maskBits`; before that, an `addr`=1 write outside a setup sequence has no effect.
- R7: Once ready, an `addr`=0 write with data bits 4:3 = 00 gives a one-cycle `cmdValid` pulse with `cmdRotate`=bit 7, `cmdSpecific`=bit 6, `cmdEoi`=bit 5 and `cmdLevel`=bits 2:0.
- R8: Once ready, an `addr`=0 write with bits 4:3 = 01 is the read/mode command: bit 5 sets `specMask` only when bit 6 is 1; bit 0 selects the in-service register (1) or request register (0) only when bit 1 is 1, and the choice persists across reads and later commands.
- R9: While `csN` and `rdN` are low, `dataOut` is `maskBits` for `addr`=1 (no prior command needed), else the selected register; otherwise `dataOut` is 0.
- R10: Read/mode bit 2 arms a poll. The next `addr`=0 read returns bit 7 = `pendValid`, bits 6:3 = 0 and bits 2:0 = `pendLevel`, frozen at the edge the read starts and taking priority over the register choice; at the read's end the poll disarms and, if bit 7 was 1, `pollAck` pulses for one cycle with `pollLevel` set to that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| wrN | input | 1 | Write strobe, active low |
| rdN | input | 1 | Read strobe, active low |
| addr | input | 1 | Address bit |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data, 0 when not reading |
| irrIn | input | 8 | Request register from the core |
| isrIn | input | 8 | In-service register from the core |
| pendValid | input | 1 | Core has an unmasked pending request |
| pendLevel | input | 3 | Winning pending level from the core |
| initReady | output | 1 | Setup sequence complete |
| levelTrig | output | 1 | Level-triggered inputs |
| intervalFour | output | 1 | Vector spacing of 4 (else 8) |
| singleMode | output | 1 | No cascade |
| vecBase | output | 8 | Setup word 2 value |
| cascadeCfg | output | 8 | Cascade map or slave ID |
| nestSpecial | output | 1 | Special nesting mode |
| bufMode | output | 1 | Buffered mode |
| masterSel | output | 1 | Master in buffered mode |
| autoEoi | output | 1 | Automatic end of interrupt |
| cpuMode | output | 1 | Processor mode select |
| maskBits | output | 8 | Mask register |
| specMask | output | 1 | Special mask mode |
| initPulse | output | 1 | One-cycle pulse on setup word 1 |
| cmdValid | output | 1 | One-cycle priority/EOI command pulse |
| cmdRotate | output | 1 | Command rotate bit |
| cmdSpecific | output | 1 | Command specific-level bit |
| cmdEoi | output | 1 | Command end-of-interrupt bit |
| cmdLevel | output | 3 | Command level |
| pollAck | output | 1 | One-cycle poll acknowledge |
| pollLevel | output | 3 | Level taken by the last poll acknowledge |

## Verification
On every cycle the assertions check that at most one load strobe fires, that a command pulse never lasts two cycles, that the mask changes only on a mask load or word 1, that word 1 leaves the mask and special mask cleared, that ready rises only on a committed write, and that an acknowledge always disarms the poll. The setup-word order with its optional words, the field positions of each word, the read multiplexing, the persistence of the read choice and the one-shot poll are shown only by the bench's scenarios, where the reference model is compared against every output each cycle.

// File: rtl/picCmdPkg.sv
package picCmdPkg;
  parameter int PIC_DW = 8;
  parameter int PIC_LW = 3;
  localparam logic [PIC_DW-1:0] SLAVE_ID_RST = PIC_DW'(7);

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_W2   = 3'd1,
    ST_W3   = 3'd2,
    ST_W4   = 3'd3,
    ST_RUN  = 3'd4
  } seqState_t;

  typedef struct packed {
    logic              w1;
    logic              w2;
    logic              w3;
    logic              w4;
    logic              mask;
    logic              op2;
    logic              op3;
    logic              pollStart;
    logic              pollEnd;
    logic [PIC_DW-1:0] data;
  } cmdStb_t;
endpackage

// File: rtl/picCtrl.sv
module picCtrl
  import picCmdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrN,
  input  logic              rdN,
  input  logic              addr,
  input  logic [PIC_DW-1:0] dataIn,
  output cmdStb_t           stb,
  output logic              initReady
);
  logic wrQ, rdQ, csQ, addrQ;
  logic [PIC_DW-1:0] dataQ;
  logic needW3Q, needW4Q;
  seqState_t stateQ, stateD;
  logic wrEvt, isW1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrQ   <= 1'b1;
      rdQ   <= 1'b1;
      csQ   <= 1'b1;
      addrQ <= 1'b0;
      dataQ <= '0;
    end else begin
      wrQ   <= wrN;
      rdQ   <= rdN;
      csQ   <= csN;
      addrQ <= addr;
      dataQ <= dataIn;
    end
  end

  assign wrEvt = !wrQ && wrN && !csQ;
  assign isW1  = wrEvt && !addrQ && dataQ[4];

  always_comb begin
    stb = '0;
    stb.data = dataQ;
    stb.pollStart = rdQ && !rdN && !csN && !addr;
    stb.pollEnd   = !rdQ && rdN && !csQ && !addrQ;
    stateD = stateQ;
    if (isW1) begin
      stb.w1 = 1'b1;
      stateD = ST_W2;
    end else if (wrEvt) begin
      unique case (stateQ)
        ST_W2: begin
          stb.w2 = 1'b1;
          stateD = needW3Q ? ST_W3 : (needW4Q ? ST_W4 : ST_RUN);
        end
        ST_W3: begin
          stb.w3 = 1'b1;
          stateD = needW4Q ? ST_W4 : ST_RUN;
        end
        ST_W4: begin
          stb.w4 = 1'b1;
          stateD = ST_RUN;
        end
        ST_RUN: begin
          if (addrQ) stb.mask = 1'b1;
          else if (dataQ[4:3] == 2'b00) stb.op2 = 1'b1;
          else stb.op3 = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      needW3Q <= 1'b0;
      needW4Q <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stb.w1) begin
        needW3Q <= !dataQ[1];
        needW4Q <= dataQ[0];
      end
    end
  end

  assign initReady = (stateQ == ST_RUN);

  a_r1_one_load: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.w1, stb.w2, stb.w3, stb.w4, stb.mask, stb.op2, stb.op3}));
  a_r4_ready_on_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initReady) |-> $past(wrEvt));
  a_r2_w1_drops_ready: assert property (@(posedge clk) disable iff (!rstN)
    stb.w1 |=> !initReady);
endmodule

// File: rtl/picRegs.sv
module picRegs
  import picCmdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cmdStb_t           stb,
  input  logic              csN,
  input  logic              rdN,
  input  logic              addr,
  input  logic [PIC_DW-1:0] irrIn,
  input  logic [PIC_DW-1:0] isrIn,
  input  logic              pendValid,
  input  logic [PIC_LW-1:0] pendLevel,
  output logic [PIC_DW-1:0] dataOut,
  output logic              levelTrig,
  output logic              intervalFour,
  output logic              singleMode,
  output logic [PIC_DW-1:0] vecBase,
  output logic [PIC_DW-1:0] cascadeCfg,
  output logic              nestSpecial,
  output logic              bufMode,
  output logic              masterSel,
  output logic              autoEoi,
  output logic              cpuMode,
  output logic [PIC_DW-1:0] maskBits,
  output logic              specMask,
  output logic              initPulse,
  output logic              cmdValid,
  output logic              cmdRotate,
  output logic              cmdSpecific,
  output logic              cmdEoi,
  output logic [PIC_LW-1:0] cmdLevel,
  output logic              pollAck,
  output logic [PIC_LW-1:0] pollLevel
);
  localparam int PAD_W = PIC_DW - 1 - PIC_LW;

  logic readIsr, pollArm;
  logic [PIC_DW-1:0] pollWordQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelTrig <= 1'b0; intervalFour <= 1'b0; singleMode <= 1'b0;
      vecBase <= '0; cascadeCfg <= SLAVE_ID_RST;
      nestSpecial <= 1'b0; bufMode <= 1'b0; masterSel <= 1'b0;
      autoEoi <= 1'b0; cpuMode <= 1'b0;
      maskBits <= '0; specMask <= 1'b0; readIsr <= 1'b0;
      initPulse <= 1'b0;
    end else begin
      initPulse <= stb.w1;
      if (stb.w1) begin
        levelTrig    <= stb.data[3];
        intervalFour <= stb.data[2];
        singleMode   <= stb.data[1];
        cascadeCfg   <= SLAVE_ID_RST;
        nestSpecial  <= 1'b0; bufMode <= 1'b0; masterSel <= 1'b0;
        autoEoi      <= 1'b0; cpuMode <= 1'b0;
        maskBits     <= '0;
        specMask     <= 1'b0;
        readIsr      <= 1'b0;
      end
      if (stb.w2) vecBase <= stb.data;
      if (stb.w3) cascadeCfg <= stb.data;
      if (stb.w4) begin
        nestSpecial <= stb.data[4];
        bufMode     <= stb.data[3];
        masterSel   <= stb.data[2];
        autoEoi     <= stb.data[1];
        cpuMode     <= stb.data[0];
      end
      if (stb.mask) maskBits <= stb.data;
      if (stb.op3) begin
        if (stb.data[6]) specMask <= stb.data[5];
        if (stb.data[1]) readIsr  <= stb.data[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid <= 1'b0; cmdRotate <= 1'b0; cmdSpecific <= 1'b0;
      cmdEoi <= 1'b0; cmdLevel <= '0;
    end else begin
      cmdValid <= stb.op2;
      if (stb.op2) begin
        cmdRotate   <= stb.data[7];
        cmdSpecific <= stb.data[6];
        cmdEoi      <= stb.data[5];
        cmdLevel    <= stb.data[PIC_LW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pollArm <= 1'b0; pollWordQ <= '0; pollAck <= 1'b0; pollLevel <= '0;
    end else begin
      pollAck <= 1'b0;
      if (stb.w1) pollArm <= 1'b0;
      else if (stb.op3) pollArm <= stb.data[2];
      else if (stb.pollEnd && pollArm) begin
        pollArm <= 1'b0;
        if (pollWordQ[PIC_DW-1]) begin
          pollAck   <= 1'b1;
          pollLevel <= pollWordQ[PIC_LW-1:0];
        end
      end
      if (stb.pollStart && pollArm)
        pollWordQ <= {pendValid, {PAD_W{1'b0}}, pendLevel};
    end
  end

  always_comb begin
    dataOut = '0;
    if (!csN && !rdN) begin
      if (addr) dataOut = maskBits;
      else if (pollArm) dataOut = pollWordQ;
      else dataOut = readIsr ? isrIn : irrIn;
    end
  end

  a_r2_w1_clears: assert property (@(posedge clk) disable iff (!rstN)
    stb.w1 |=> (maskBits == '0) && !specMask);
  a_r7_cmd_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);
  a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.w1 && !stb.mask) |=> $stable(maskBits));
  a_r10_ack_disarms: assert property (@(posedge clk) disable iff (!rstN)
    pollAck |-> !pollArm);
endmodule

// File: rtl/picCmdIf.sv
module picCmdIf
  import picCmdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrN,
  input  logic              rdN,
  input  logic              addr,
  input  logic [PIC_DW-1:0] dataIn,
  output logic [PIC_DW-1:0] dataOut,
  input  logic [PIC_DW-1:0] irrIn,
  input  logic [PIC_DW-1:0] isrIn,
  input  logic              pendValid,
  input  logic [PIC_LW-1:0] pendLevel,
  output logic              initReady,
  output logic              levelTrig,
  output logic              intervalFour,
  output logic              singleMode,
  output logic [PIC_DW-1:0] vecBase,
  output logic [PIC_DW-1:0] cascadeCfg,
  output logic              nestSpecial,
  output logic              bufMode,
  output logic              masterSel,
  output logic              autoEoi,
  output logic              cpuMode,
  output logic [PIC_DW-1:0] maskBits,
  output logic              specMask,
  output logic              initPulse,
  output logic              cmdValid,
  output logic              cmdRotate,
  output logic              cmdSpecific,
  output logic              cmdEoi,
  output logic [PIC_LW-1:0] cmdLevel,
  output logic              pollAck,
  output logic [PIC_LW-1:0] pollLevel
);
  cmdStb_t stb;

  picCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .rdN(rdN), .addr(addr),
    .dataIn(dataIn), .stb(stb), .initReady(initReady)
  );

  picRegs u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .csN(csN), .rdN(rdN), .addr(addr),
    .irrIn(irrIn), .isrIn(isrIn), .pendValid(pendValid), .pendLevel(pendLevel),
    .dataOut(dataOut), .levelTrig(levelTrig), .intervalFour(intervalFour),
    .singleMode(singleMode), .vecBase(vecBase), .cascadeCfg(cascadeCfg),
    .nestSpecial(nestSpecial), .bufMode(bufMode), .masterSel(masterSel),
    .autoEoi(autoEoi), .cpuMode(cpuMode), .maskBits(maskBits),
    .specMask(specMask), .initPulse(initPulse), .cmdValid(cmdValid),
    .cmdRotate(cmdRotate), .cmdSpecific(cmdSpecific), .cmdEoi(cmdEoi),
    .cmdLevel(cmdLevel), .pollAck(pollAck), .pollLevel(pollLevel)
  );
endmodule

// File: tb/picCmdIf_bench.sv
`timescale 1ns/1ps
module picCmdIf_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic csN = 1'b1, wrN = 1'b1, rdN = 1'b1, addr = 1'b0;
  logic [7:0] dataIn = '0, irrIn = 8'h3C, isrIn = 8'h81;
  logic pendValid = 1'b0;
  logic [2:0] pendLevel = '0;
  logic [7:0] dataOut, vecBase, cascadeCfg, maskBits;
  logic initReady, levelTrig, intervalFour, singleMode, nestSpecial, bufMode;
  logic masterSel, autoEoi, cpuMode, specMask, initPulse, cmdValid;
  logic cmdRotate, cmdSpecific, cmdEoi, pollAck;
  logic [2:0] cmdLevel, pollLevel;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  picCmdIf u_picCmdIf (.*);

  // reference model state
  int mSeq;  // 0 idle, 2/3/4 awaiting word, 5 running
  bit mNeed3, mNeed4, mReady, mLvl, mInt4, mSingle, mNest, mBuf, mMst, mAeoi, mCpu;
  bit mSpec, mIsrSel, mArm, mInitP, mCmd, mRot, mSel, mEoi, mAck;
  logic [7:0] mVec, mCasc, mMask, mPollWord;
  logic [2:0] mCmdLvl, mAckLvl;
  bit pWr, pRd, pCs, pAddr;
  logic [7:0] pData;

  always @(posedge clk) begin
    if (!rstN) begin
      mSeq = 0; mNeed3 = 0; mNeed4 = 0; mReady = 0; mLvl = 0; mInt4 = 0;
      mSingle = 0; mNest = 0; mBuf = 0; mMst = 0; mAeoi = 0; mCpu = 0;
      mSpec = 0; mIsrSel = 0; mArm = 0; mInitP = 0; mCmd = 0; mRot = 0;
      mSel = 0; mEoi = 0; mAck = 0; mVec = 0; mCasc = 8'h07; mMask = 0;
      mPollWord = 0; mCmdLvl = 0; mAckLvl = 0;
      pWr = 1; pRd = 1; pCs = 1; pAddr = 0; pData = 0;
    end else begin
      bit wrE, rdS, rdE;
      wrE = !pWr && wrN && !pCs;
      rdS = pRd && !rdN && !csN && !addr;
      rdE = !pRd && rdN && !pCs && !pAddr;
      mInitP = 0; mCmd = 0; mAck = 0;
      if (wrE && !pAddr && pData[4]) begin
        mInitP = 1; mReady = 0; mSeq = 2;
        mLvl = pData[3]; mInt4 = pData[2]; mSingle = pData[1];
        mNeed3 = !pData[1]; mNeed4 = pData[0];
        mMask = 0; mSpec = 0; mIsrSel = 0; mCasc = 8'h07; mArm = 0;
        {mNest, mBuf, mMst, mAeoi, mCpu} = 5'b0;
      end else if (wrE) begin
        case (mSeq)
          2: begin mVec = pData; mSeq = mNeed3 ? 3 : (mNeed4 ? 4 : 5); end
          3: begin mCasc = pData; mSeq = mNeed4 ? 4 : 5; end
          4: begin {mNest, mBuf, mMst, mAeoi, mCpu} = pData[4:0]; mSeq = 5; end
          5: begin
            if (pAddr) mMask = pData;
            else if (pData[4:3] == 2'b00) begin
              mCmd = 1; {mRot, mSel, mEoi} = pData[7:5]; mCmdLvl = pData[2:0];
            end else begin
              if (pData[6]) mSpec = pData[5];
              if (pData[1]) mIsrSel = pData[0];
              mArm = pData[2];
            end
          end
          default: ;
        endcase
        mReady = (mSeq == 5);
      end else if (rdE && mArm) begin
        mArm = 0;
        if (mPollWord[7]) begin mAck = 1; mAckLvl = mPollWord[2:0]; end
      end
      if (rdS && mArm) mPollWord = {pendValid, 4'b0, pendLevel};
      pWr = wrN; pRd = rdN; pCs = csN; pAddr = addr; pData = dataIn;
    end
  end

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every output against the model on every clock
  always @(negedge clk) if (!done) begin
    logic [7:0] expD;
    chk("R4", "initReady", 8'(initReady), 8'(mReady));
    chk("R3", "levelTrig", 8'(levelTrig), 8'(mLvl));
    chk("R3", "intervalFour", 8'(intervalFour), 8'(mInt4));
    chk("R3", "singleMode", 8'(singleMode), 8'(mSingle));
    chk("R4", "vecBase", vecBase, mVec);
    chk("R4", "cascadeCfg", cascadeCfg, mCasc);
    chk("R5", "word4 fields", 8'({nestSpecial, bufMode, masterSel, autoEoi, cpuMode}),
        8'({mNest, mBuf, mMst, mAeoi, mCpu}));
    chk("R6", "maskBits", maskBits, mMask);
    chk("R8", "specMask", 8'(specMask), 8'(mSpec));
    chk("R2", "initPulse", 8'(initPulse), 8'(mInitP));
    chk("R7", "cmdValid", 8'(cmdValid), 8'(mCmd));
    chk("R7", "cmd fields", 8'({cmdRotate, cmdSpecific, cmdEoi, cmdLevel}),
        8'({mRot, mSel, mEoi, mCmdLvl}));
    chk("R10", "pollAck", 8'(pollAck), 8'(mAck));
    chk("R10", "pollLevel", 8'(pollLevel), 8'(mAckLvl));
    if (!csN && !rdN && !pRd) begin
      expD = addr ? mMask : (mArm ? mPollWord : (mIsrSel ? isrIn : irrIn));
      chk("R9", "dataOut read", dataOut, expD);
    end else if (rdN || csN) begin
      chk("R9", "dataOut idle", dataOut, 8'h00);
    end
  end

  task automatic wrCyc(logic a, logic [7:0] d, logic sel = 1'b1);
    @(negedge clk); csN = !sel; addr = a; dataIn = d; wrN = 0;
    @(negedge clk);
    @(negedge clk); wrN = 1;
    @(negedge clk); csN = 1;
  endtask

  task automatic rdCyc(logic a, string req, logic [7:0] exp);
    @(negedge clk); csN = 0; addr = a; rdN = 0;
    @(negedge clk);
    @(negedge clk); chk(req, "explicit read", dataOut, exp);
    rdN = 1;
    @(negedge clk); csN = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R2", "reset cascade", cascadeCfg, 8'h07);
    chk("R4", "reset not ready", 8'(initReady), 8'h00);
    rstN = 1;
    // R6: mask write before setup ignored
    wrCyc(1, 8'hFF);
    chk("R6", "pre-init mask", maskBits, 8'h00);
    // R3 R4 R5: word1 single, word4 needed
    wrCyc(0, 8'h13);
    chk("R2", "initPulse after word1", 8'(initPulse), 8'h01);
    wrCyc(1, 8'h40);
    chk("R4", "word2 loaded", vecBase, 8'h40);
    chk("R4", "not ready before word4", 8'(initReady), 8'h00);
    wrCyc(1, 8'h1F);
    chk("R5", "word4 all set", 8'({nestSpecial, bufMode, masterSel, autoEoi, cpuMode}), 8'h1F);
    chk("R4", "ready", 8'(initReady), 8'h01);
    // R1: deselected write ignored
    wrCyc(1, 8'h5A, 1'b0);
    chk("R1", "cs high ignored", maskBits, 8'h00);
    wrCyc(1, 8'hA5);
    chk("R6", "mask load", maskBits, 8'hA5);
    rdCyc(1, "R9", 8'hA5);
    rdCyc(0, "R9", 8'h3C);
    // R7 command pulse
    wrCyc(0, 8'hE3);
    chk("R7", "pulse after write", 8'(cmdValid), 8'h01);
    wrCyc(0, 8'h65);
    // R8 read select and special mask
    wrCyc(0, 8'h0B);
    rdCyc(0, "R8", 8'h81);
    wrCyc(0, 8'h08);
    rdCyc(0, "R8", 8'h81);
    wrCyc(0, 8'h28);
    chk("R8", "smm without enable", 8'(specMask), 8'h00);
    wrCyc(0, 8'h68);
    chk("R8", "smm set", 8'(specMask), 8'h01);
    wrCyc(0, 8'h48);
    chk("R8", "smm clear", 8'(specMask), 8'h00);
    // R10 poll
    pendValid = 1; pendLevel = 3'd5;
    wrCyc(0, 8'h0C);
    rdCyc(0, "R10", 8'h85);
    chk("R10", "ack level", 8'(pollLevel), 8'h05);
    rdCyc(0, "R10", 8'h81);
    pendValid = 0; pendLevel = 3'd3;
    wrCyc(0, 8'h0C);
    rdCyc(1, "R10", 8'hA5);
    rdCyc(0, "R10", 8'h03);
    // R2 R3 R4: restart with cascade and no word4
    wrCyc(0, 8'h1C);
    chk("R2", "mask cleared", maskBits, 8'h00);
    chk("R5", "word4 cleared", 8'({nestSpecial, bufMode, masterSel, autoEoi, cpuMode}), 8'h00);
    wrCyc(0, 8'h1D);
    chk("R2", "restart in word2 state", 8'(singleMode), 8'h00);
    wrCyc(1, 8'h88);
    wrCyc(1, 8'h04);
    chk("R4", "word3 loaded", cascadeCfg, 8'h04);
    chk("R4", "still waiting word4", 8'(initReady), 8'h00);
    wrCyc(1, 8'h02);
    chk("R5", "autoEoi", 8'(autoEoi), 8'h01);
    rdCyc(0, "R2", 8'h3C);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule